// File: doc/BRIEF.md
# Smart Card Character Receiver

This block is the receive half of a half-duplex smart card serial link. It watches a single open-drain line, finds the falling edge of a start bit and samples the character that follows: a start bit, eight data bits sent least significant first, and an even parity bit. The length of one bit, the elementary time unit, is a programmable count of oversampling clocks. Each bit is decided by a majority vote of three samples taken around mid-bit.

When the parity bit does not match the data, the receiver pulls the line low for one bit time. It starts half a bit time after the parity bit ends. This tells the sender to transmit the same character again. The errored byte is still written to the data register, where software can inspect it. It never sets the receive-full flag and never raises a transfer request, so an external data mover only ever sees good bytes. A good byte sets the receive-full flag and raises a transfer request, and the mover's read acknowledge clears the flag. A good byte that arrives while the flag is still set is discarded and the overrun flag is set. With the interrupt enable set, receive and error interrupt requests follow the flags.

The controller is a state machine with six states. `S_IDLE` hunts for a falling edge and moves to `S_START` on one. `S_START` checks the voted start bit: a low value moves to `S_DATA`, a high value is a false start and returns to `S_IDLE`. `S_DATA` shifts in eight bits and then moves to `S_PARITY`. At the end of the parity bit, a match returns to `S_IDLE`. A mismatch moves to `S_ERR_WAIT`, which waits half a bit time and then moves to `S_ERR_DRIVE`. `S_ERR_DRIVE` holds the line low for one bit time and then returns to `S_IDLE`.

Top module: `scrx_receiver`

## Requirements
- R1: A frame is a low start bit, eight data bits sent least significant bit first, and a parity bit that makes the count of ones across the data and parity bits even. Each bit lasts `etu_div` clocks.
- R2: When parity fails, `flag_parity` is set and the byte is written to `rx_data`. `flag_full` is not set and `xfer_req` does not rise.
- R3: When parity fails, `line_drive_low` is asserted for exactly `etu_div` consecutive clocks. It starts half a bit time after the parity bit ends. At all other times it stays low.
- R4: When parity is good and `flag_full` is clear, the byte is written to `rx_data`, and `flag_full` and `xfer_req` are set. `flag_parity` is left unchanged.
- R5: A one-clock pulse on `mover_ack` clears `flag_full` and `xfer_req`. Nothing else clears them, apart from reset.
- R6: When a good frame completes while `flag_full` is set, `flag_overrun` is set. The new byte is discarded, `rx_data` is unchanged and `flag_full` stays set.
- R7: `irq_rx` equals `flag_full` AND `rx_int_en`. `irq_err` equals (`flag_parity` OR `flag_overrun`) AND `rx_int_en`.
- R8: A one-clock pulse on `clr_parity` clears `flag_parity`, and a pulse on `clr_overrun` clears `flag_overrun`. Software clears `flag_parity` before the next parity bit.
- R9: A falling edge whose start bit is voted high is a false start. The receiver returns to hunting without changing any flag, `rx_data` or the line.
- R10: Each bit is decided by a majority of three consecutive samples around mid-bit, so a glitch of one clock inside a bit does not change the received value.
- R11: While `rst_n` is low at a clock edge, all flags, `rx_data` and all interrupt and request outputs go to zero. The line is released and the receiver returns to hunting.
- R12: `etu_div` is at least 8 and changes only while the line is idle and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| etu_div | input | DIVW | Clocks per bit time (at least 8) |
| line_in | input | 1 | Serial line level as seen at the pin |
| rx_int_en | input | 1 | Enables both interrupt requests |
| mover_ack | input | 1 | Data mover has read `rx_data`; clears full |
| clr_parity | input | 1 | Software clear of the parity error flag |
| clr_overrun | input | 1 | Software clear of the overrun flag |
| line_drive_low | output | 1 | Pulls the open-drain line low for error signalling |
| rx_data | output | 8 | Received data register |
| flag_full | output | 1 | A good byte waits in `rx_data` |
| flag_parity | output | 1 | Parity error flag |
| flag_overrun | output | 1 | Overrun flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |
| xfer_req | output | 1 | Transfer request to the data mover |

## Verification
The assertions assume that `etu_div` is at least 8 and changes only between frames. They also assume that software does not clear `flag_parity` while an error signal is being driven. The drive-length check additionally relies on a stable bit time during the error slot. The stimulus picks a new random bit time from 8 to 31 only while the line is idle, and issues flag clears and mover acknowledges only in the gaps between frames. Around those constraints it varies the data bytes, parity faults, the interrupt enable and the acknowledge timing at random, and adds directed frames for false starts, glitches and overrun.

// File: rtl/scrx_pkg.sv
package scrx_pkg;

    localparam int unsigned SC_DATA_BITS = 8;
    localparam int unsigned SC_MIN_ETU   = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_ERR_WAIT,
        S_ERR_DRIVE
    } rx_state_t;

endpackage

// File: rtl/scrx_sync.sv
module scrx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s,
    output logic line_fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], line_raw};
        end
    end

    assign line_s    = pipe[STAGES-1];
    assign line_fall = !pipe[STAGES-1] && pipe[STAGES];
endmodule

// File: rtl/scrx_bit_timer.sv
module scrx_bit_timer #(
    parameter int unsigned DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] etu,
    input  logic            restart,
    input  logic            line_s,
    output logic            bit_end,
    output logic            half_end,
    output logic            bit_val
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] mid;
    logic [2:0]      votes;

    assign mid      = etu >> 1;
    assign bit_end  = (cnt == etu - 1'b1);
    assign half_end = (cnt == mid - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || restart || bit_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // three consecutive samples centred on mid-bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            votes <= 3'b111;
        end else begin
            if (cnt == mid - 1'b1) votes[0] <= line_s;
            if (cnt == mid)        votes[1] <= line_s;
            if (cnt == mid + 1'b1) votes[2] <= line_s;
        end
    end

    assign bit_val = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);

    assert_etu_min_R12: assert property (@(posedge clk) disable iff (!rst_n)
        etu >= DIVW'(scrx_pkg::SC_MIN_ETU));
endmodule

// File: rtl/scrx_status.sv
module scrx_status #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_good,
    input  logic          frame_bad,
    input  logic [DW-1:0] byte_in,
    input  logic          mover_ack,
    input  logic          clr_parity,
    input  logic          clr_overrun,
    input  logic          rx_int_en,
    output logic [DW-1:0] rx_data,
    output logic          flag_full,
    output logic          flag_parity,
    output logic          flag_overrun,
    output logic          irq_rx,
    output logic          irq_err,
    output logic          xfer_req
);
    logic still_full;

    // an acknowledge in the same cycle frees the register first
    assign still_full = flag_full && !mover_ack;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data      <= '0;
            flag_full    <= 1'b0;
            flag_parity  <= 1'b0;
            flag_overrun <= 1'b0;
        end else begin
            if (frame_bad) begin
                rx_data <= byte_in;
            end else if (frame_good && !still_full) begin
                rx_data <= byte_in;
            end

            if (frame_good && !still_full) begin
                flag_full <= 1'b1;
            end else if (mover_ack) begin
                flag_full <= 1'b0;
            end

            if (frame_bad) begin
                flag_parity <= 1'b1;
            end else if (clr_parity) begin
                flag_parity <= 1'b0;
            end

            if (frame_good && still_full) begin
                flag_overrun <= 1'b1;
            end else if (clr_overrun) begin
                flag_overrun <= 1'b0;
            end
        end
    end

    assign xfer_req = flag_full;
    assign irq_rx   = flag_full && rx_int_en;
    assign irq_err  = (flag_parity || flag_overrun) && rx_int_en;

    assert_err_no_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_parity) |-> !$rose(flag_full));

    assert_full_clear_by_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_full) |-> $past(mover_ack));

    assert_overrun_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_overrun) |-> $stable(rx_data));
endmodule

// File: rtl/scrx_receiver.sv
module scrx_receiver #(
    parameter int unsigned DIVW        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] etu_div,
    input  logic            line_in,
    input  logic            rx_int_en,
    input  logic            mover_ack,
    input  logic            clr_parity,
    input  logic            clr_overrun,
    output logic            line_drive_low,
    output logic [7:0]      rx_data,
    output logic            flag_full,
    output logic            flag_parity,
    output logic            flag_overrun,
    output logic            irq_rx,
    output logic            irq_err,
    output logic            xfer_req
);
    import scrx_pkg::*;

    localparam int unsigned DW   = SC_DATA_BITS;
    localparam int unsigned IDXW = $clog2(DW);

    rx_state_t       state, state_n;
    logic            line_s, line_fall;
    logic            restart, bit_end, half_end, bit_val;
    logic [DW-1:0]   shreg;
    logic [IDXW-1:0] idx;
    logic            frame_good, frame_bad;
    logic            drive_q;
    logic [DIVW:0]   drv_run;

    scrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (line_in),
        .line_s    (line_s),
        .line_fall (line_fall)
    );

    scrx_bit_timer #(.DIVW(DIVW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .etu      (etu_div),
        .restart  (restart),
        .line_s   (line_s),
        .bit_end  (bit_end),
        .half_end (half_end),
        .bit_val  (bit_val)
    );

    // next state and frame outcome
    always_comb begin
        state_n    = state;
        restart    = 1'b0;
        frame_good = 1'b0;
        frame_bad  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (line_fall) begin
                    state_n = S_START;
                    restart = 1'b1;
                end
            end
            S_START: begin
                if (bit_end) state_n = bit_val ? S_IDLE : S_DATA;
            end
            S_DATA: begin
                if (bit_end && idx == IDXW'(DW - 1)) state_n = S_PARITY;
            end
            S_PARITY: begin
                if (bit_end) begin
                    if (^{shreg, bit_val}) begin
                        state_n   = S_ERR_WAIT;
                        frame_bad = 1'b1;
                    end else begin
                        state_n    = S_IDLE;
                        frame_good = 1'b1;
                    end
                end
            end
            S_ERR_WAIT: begin
                if (half_end) begin
                    state_n = S_ERR_DRIVE;
                    restart = 1'b1;
                end
            end
            S_ERR_DRIVE: begin
                if (bit_end) state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // data shift path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (state == S_START) begin
            idx <= '0;
        end else if (state == S_DATA && bit_end) begin
            shreg <= {bit_val, shreg[DW-1:1]};
            idx   <= idx + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= (state_n == S_ERR_DRIVE);
    end

    assign line_drive_low = drive_q;

    scrx_status #(.DW(DW)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_good   (frame_good),
        .frame_bad    (frame_bad),
        .byte_in      (shreg),
        .mover_ack    (mover_ack),
        .clr_parity   (clr_parity),
        .clr_overrun  (clr_overrun),
        .rx_int_en    (rx_int_en),
        .rx_data      (rx_data),
        .flag_full    (flag_full),
        .flag_parity  (flag_parity),
        .flag_overrun (flag_overrun),
        .irq_rx       (irq_rx),
        .irq_err      (irq_err),
        .xfer_req     (xfer_req)
    );

    // length of the current low drive, for the window check
    always_ff @(posedge clk) begin
        if (!rst_n || !drive_q) drv_run <= '0;
        else                    drv_run <= drv_run + 1'b1;
    end

    assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !line_drive_low);

    assert_drive_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> (drv_run < {1'b0, etu_div}));

    assert_drive_after_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> flag_parity);
endmodule

// File: tb/scrx_receiver_tb.sv
module scrx_receiver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIVW       = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DIVW-1:0] etu_div = 8'd16;
    logic            bench_line = 1'b1;
    logic            line_in;
    logic            rx_int_en = 1'b1;
    logic            mover_ack = 1'b0;
    logic            clr_parity = 1'b0;
    logic            clr_overrun = 1'b0;
    logic            line_drive_low;
    logic [7:0]      rx_data;
    logic            flag_full, flag_parity, flag_overrun;
    logic            irq_rx, irq_err, xfer_req;

    int checks = 0;
    int fails  = 0;
    int drv_cnt = 0;
    logic drv_mid;
    logic drv_early;

    logic [7:0] m_data = 8'h00;
    logic       m_full = 1'b0, m_per = 1'b0, m_ovr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain wired-AND line
    assign line_in = bench_line & ~line_drive_low;

    scrx_receiver #(.DIVW(DIVW)) u_dut (
        .clk(clk), .rst_n(rst_n), .etu_div(etu_div), .line_in(line_in),
        .rx_int_en(rx_int_en), .mover_ack(mover_ack), .clr_parity(clr_parity),
        .clr_overrun(clr_overrun), .line_drive_low(line_drive_low),
        .rx_data(rx_data), .flag_full(flag_full), .flag_parity(flag_parity),
        .flag_overrun(flag_overrun), .irq_rx(irq_rx), .irq_err(irq_err),
        .xfer_req(xfer_req)
    );

    always @(posedge clk) if (line_drive_low) drv_cnt = drv_cnt + 1;

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // glitch_bit < 0 means none
    task automatic send_frame(input logic [7:0] b, input logic bad, input int glitch_bit);
        logic [9:0] bits;
        int e;
        e = int'(etu_div);
        bits = {even_par(b) ^ bad, b[7:0]};
        drv_cnt = 0;
        @(negedge clk);
        bench_line = 1'b0;
        wait_cycles(e);
        for (int i = 0; i < 9; i++) begin
            bench_line = bits[i];
            if (i == glitch_bit) begin
                wait_cycles(e / 2);
                bench_line = ~bits[i];
                wait_cycles(1);
                bench_line = bits[i];
                wait_cycles(e - e / 2 - 1);
            end else begin
                wait_cycles(e);
            end
        end
        bench_line = 1'b1;
        drv_early = line_drive_low;
        wait_cycles(e);
        drv_mid = line_drive_low;
        wait_cycles(2 * e);
        if (bad) begin
            m_data = b;
            m_per  = 1'b1;
        end else if (m_full) begin
            m_ovr = 1'b1;
        end else begin
            m_full = 1'b1;
            m_data = b;
        end
    endtask

    task automatic pulse_ack();
        mover_ack = 1'b1; wait_cycles(1); mover_ack = 1'b0;
        m_full = 1'b0;
    endtask

    task automatic pulse_clr(input logic p, input logic o);
        clr_parity = p; clr_overrun = o; wait_cycles(1);
        clr_parity = 1'b0; clr_overrun = 1'b0;
        if (p) m_per = 1'b0;
        if (o) m_ovr = 1'b0;
    endtask

    task automatic check_state(input string tag);
        check({tag, " R1 rx_data"}, rx_data, m_data);
        check({tag, " R4 flag_full"}, flag_full, m_full);
        check({tag, " R2 flag_parity"}, flag_parity, m_per);
        check({tag, " R6 flag_overrun"}, flag_overrun, m_ovr);
        check({tag, " R5 xfer_req"}, xfer_req, m_full);
        check({tag, " R7 irq_rx"}, irq_rx, m_full & rx_int_en);
        check({tag, " R7 irq_err"}, irq_err, (m_per | m_ovr) & rx_int_en);
    endtask

    task automatic check_drive(input string tag, input logic bad);
        check({tag, " R3 drive count"}, drv_cnt, bad ? int'(etu_div) : 0);
        check({tag, " R3 drive in slot"}, drv_mid, bad);
        check({tag, " R3 no drive before slot"}, drv_early, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5C0A11));
        wait_cycles(4);
        // R11: reset state
        check("R11 reset drive", line_drive_low, 1'b0);
        check_state("R11 reset");
        rst_n = 1'b1;
        wait_cycles(5);

        // R1 R4: good frame
        send_frame(8'hA5, 1'b0, -1);
        check_state("R4 good A5");
        check_drive("R4 good A5", 1'b0);

        // R6: overrun with full set
        send_frame(8'h3C, 1'b0, -1);
        check_state("R6 overrun");
        check("R6 data kept", rx_data, 8'hA5);

        // R5 and R8
        pulse_ack();
        check("R5 ack clears full", flag_full, 1'b0);
        pulse_clr(1'b0, 1'b1);
        check("R8 overrun cleared", flag_overrun, 1'b0);

        // R2 R3: parity error
        send_frame(8'hFF, 1'b1, -1);
        check_state("R2 bad FF");
        check_drive("R2 bad FF", 1'b1);
        check("R2 no full", flag_full, 1'b0);
        pulse_clr(1'b1, 1'b0);
        check("R8 parity cleared", flag_parity, 1'b0);

        // retransmitted copy arrives good
        send_frame(8'hFF, 1'b0, -1);
        check_state("R1 retransmit FF");

        // R9: false start
        pulse_ack();
        drv_cnt = 0;
        bench_line = 1'b0; wait_cycles(2); bench_line = 1'b1;
        wait_cycles(3 * int'(etu_div));
        check_state("R9 false start");
        check("R9 no drive", drv_cnt, 0);
        send_frame(8'h00, 1'b0, -1);
        check_state("R9 after false start");

        // R10: single-clock glitch in a data bit and in parity
        pulse_ack();
        send_frame(8'h96, 1'b0, 3);
        check_state("R10 glitch data");
        pulse_ack();
        send_frame(8'h41, 1'b0, 8);
        check_state("R10 glitch parity");
        check_drive("R10 glitch parity", 1'b0);

        // R7: interrupts disabled
        rx_int_en = 1'b0;
        send_frame(8'h77, 1'b1, -1);
        check_state("R7 disabled");
        pulse_clr(1'b1, 1'b1);
        rx_int_en = 1'b1;

        // R12 random mix with programmable bit time
        for (int k = 0; k < 24; k++) begin
            logic [7:0] b;
            logic bad;
            etu_div = DIVW'(8 + ($urandom % 24));
            b = 8'($urandom);
            bad = (($urandom % 4) == 0);
            rx_int_en = 1'($urandom);
            if ($urandom % 2) pulse_ack();
            if ($urandom % 2) pulse_clr(1'b1, 1'($urandom));
            wait_cycles(2);
            send_frame(b, bad, ($urandom % 3 == 0) ? int'($urandom % 9) : -1);
            check_state("R12 random");
            check_drive("R12 random", bad);
        end

        // R11: reset mid-frame
        bench_line = 1'b0;
        wait_cycles(3 * int'(etu_div));
        rst_n = 1'b0;
        wait_cycles(1);
        m_data = 8'h00; m_full = 1'b0; m_per = 1'b0; m_ovr = 1'b0;
        bench_line = 1'b1;
        wait_cycles(2);
        check_state("R11 reset mid-frame");
        rst_n = 1'b1;
        wait_cycles(5);
        send_frame(8'h5A, 1'b0, -1);
        check_state("R11 after reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule